// File: doc/BRIEF.md
# Keyboard Port Trap Controller

This block sits beside the I/O decode of a chipset and watches accesses to the two legacy keyboard controller ports, the data port at 60h and the command/status port at 64h. Each access arrives as a one-clock strobe together with a port select, a direction flag and eight data bits. A six-bit control register decides which of the four port/direction combinations are trapped, whether the USB interrupt request raises a system-management interrupt, and whether the gate-control handshake for address line 20 may pass through untrapped.

A trapped access sets a sticky status bit and produces a one-clock trap pulse. The SMI output is a level. It stays high while any status bit is set whose enable bit is also set. Software clears status bits by writing ones to them. When pass-through is enabled, a small tracker follows the gate handshake and suppresses the trap, the status update and the SMI for the accesses that belong to it. Any access that breaks the handshake ends it and is handled as a normal access.

Top module: `kbc_trap_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the control register, all status bits, `trap_o` and `smi_o` are 0.
- R2: A clock with `cfg_we_i` high loads `cfg_wdata_i` into the control register, which is read on `ctrl_o`. Bit 0 enables port 60h reads, bit 1 port 60h writes, bit 2 port 64h reads, bit 3 port 64h writes, bit 4 the USB request, and bit 5 pass-through. An access has index 2*`io_port_i`+`io_wr_i`, where `io_port_i`=0 selects 60h and 1 selects 64h.
- R3: An access outside a pass-through sequence whose enable bit is set sets status bit [index] at the strobe edge and drives `trap_o` high for exactly the following clock. An access whose enable bit is clear changes neither the status bits nor `trap_o`.
- R4: A clock with `sts_clr_i` high in some bit positions clears those status bits and leaves the other bits unchanged.
- R5: `smi_o` is high exactly while some status bit k is 1 and enable bit k is 1. Clearing the enable bit drops `smi_o` even though the status bit remains set.
- R6: When a set event and a clear request for the same status bit fall in the same clock, the bit ends up set.
- R7: In every clock where `usb_irq_i` is high and enable bit 4 is set, status bit 4 is set. This source never pulses `trap_o`.
- R8: With bit 5 set, the following sequence raises no trap, no status bit and no SMI, even with all enables set: one or more writes of D1h to 64h, then one write of any value to 60h, then zero or more reads of 64h, then a write of FFh to 64h.
- R9: After the closing FFh write the tracker is idle, so the next access is handled as if no sequence had occurred.
- R10: An access that does not fit the next step of the sequence ends it at once. That access is trapped per R3, and the tracker is idle for the access after it.
- R11: With bit 5 clear, a D1h write to 64h is trapped like any other 64h write. Clearing bit 5 during a sequence abandons that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_vld_i | input | 1 | One-clock strobe marking a decoded keyboard-port access |
| io_port_i | input | 1 | 0 = port 60h, 1 = port 64h |
| io_wr_i | input | 1 | 1 = write, 0 = read |
| io_data_i | input | DW | Data of the access (write data) |
| usb_irq_i | input | 1 | USB interrupt request level |
| cfg_we_i | input | 1 | Load strobe for the control register |
| cfg_wdata_i | input | 6 | New control register value |
| sts_clr_i | input | 5 | Write-one-to-clear mask for the status bits |
| ctrl_o | output | 6 | Control register contents |
| sts_o | output | 5 | Sticky status bits, one per source |
| trap_o | output | 1 | One-clock pulse for each trapped access |
| smi_o | output | 1 | System-management interrupt level |

## Verification
A tracker stuck in the wrong state shows at the ports on the next keyboard access. Either an access inside the handshake produces a trap pulse and a status bit, or a stray access escapes its trap, and this is visible one clock after the strobe. For that reason each deviation case is followed by a plain 60h write whose trap reveals whether the tracker went back to idle. A wrong status bit shows on `sts_o` and `smi_o` in the clock after the event, and it remains visible until it is cleared. Sweeping every enable pattern against every access type exposes any miswired index at once.

// File: rtl/kbc_trap_pkg.sv
package kbc_trap_pkg;
  localparam int NUM_TRAP = 4;
  localparam int NUM_SRC  = NUM_TRAP + 1;
  localparam int CTRL_W   = NUM_SRC + 1;
  localparam int SRC_USB  = NUM_TRAP;
  localparam int EN_PASS  = NUM_SRC;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CMD  = 2'd1,
    SEQ_DATA = 2'd2
  } seq_st_e;
endpackage

// File: rtl/kbc_seq_fsm.sv
module kbc_seq_fsm
  import kbc_trap_pkg::*;
#(
  parameter int          DW       = 8,
  parameter logic [DW-1:0] CMD_GATE = 8'hD1,
  parameter logic [DW-1:0] CMD_END  = 8'hFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          vld_i,
  input  logic          port_i,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  output logic          in_seq_o,
  output seq_st_e       st_o
);
  seq_st_e st_q, st_d;
  logic wr64, rd64, wr60;

  assign wr64 = port_i & wr_i;
  assign rd64 = port_i & ~wr_i;
  assign wr60 = ~port_i & wr_i;

  always_comb begin
    st_d     = st_q;
    in_seq_o = 1'b0;
    if (!en_i) begin
      st_d = SEQ_IDLE;
    end else if (vld_i) begin
      unique case (st_q)
        SEQ_IDLE: begin
          if (wr64 && data_i == CMD_GATE) begin
            in_seq_o = 1'b1;
            st_d     = SEQ_CMD;
          end
        end
        SEQ_CMD: begin
          if (wr64 && data_i == CMD_GATE) begin
            in_seq_o = 1'b1;
          end else if (wr60) begin
            in_seq_o = 1'b1;
            st_d     = SEQ_DATA;
          end else begin
            st_d = SEQ_IDLE;
          end
        end
        SEQ_DATA: begin
          if (rd64) begin
            in_seq_o = 1'b1;
          end else if (wr64 && data_i == CMD_END) begin
            in_seq_o = 1'b1;
            st_d     = SEQ_IDLE;
          end else begin
            st_d = SEQ_IDLE;
          end
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEQ_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/kbc_trap_status.sv
module kbc_trap_status #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [NUM_SRC-1:0] sts_o,
  output logic               smi_o
);
  logic [NUM_SRC-1:0] sts_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr_i) | set_i;
  end

  assign sts_o = sts_q;
  assign smi_o = |(sts_q & en_i);
endmodule

// File: rtl/kbc_trap_ctrl.sv
module kbc_trap_ctrl
  import kbc_trap_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] CMD_GATE = 8'hD1,
  parameter logic [DW-1:0] CMD_END  = 8'hFF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               io_vld_i,
  input  logic               io_port_i,
  input  logic               io_wr_i,
  input  logic [DW-1:0]      io_data_i,
  input  logic               usb_irq_i,
  input  logic               cfg_we_i,
  input  logic [CTRL_W-1:0]  cfg_wdata_i,
  input  logic [NUM_SRC-1:0] sts_clr_i,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic [NUM_SRC-1:0] sts_o,
  output logic               trap_o,
  output logic               smi_o
);
  logic [CTRL_W-1:0]   ctrl_q;
  logic [NUM_SRC-1:0]  set_vec;
  logic [NUM_TRAP-1:0] acc_hit;
  logic [1:0]          acc_idx;
  logic                in_seq;
  logic                trap_q;
  seq_st_e             seq_st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (cfg_we_i) ctrl_q <= cfg_wdata_i;
  end

  assign acc_idx = {io_port_i, io_wr_i};

  for (genvar k = 0; k < NUM_TRAP; k++) begin : g_trap
    assign acc_hit[k] = io_vld_i && (acc_idx == 2'(k));
    assign set_vec[k] = acc_hit[k] && ctrl_q[k] && !in_seq;
  end
  assign set_vec[SRC_USB] = usb_irq_i && ctrl_q[SRC_USB];

  kbc_seq_fsm #(
    .DW(DW), .CMD_GATE(CMD_GATE), .CMD_END(CMD_END)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ctrl_q[EN_PASS]),
    .vld_i    (io_vld_i),
    .port_i   (io_port_i),
    .wr_i     (io_wr_i),
    .data_i   (io_data_i),
    .in_seq_o (in_seq),
    .st_o     (seq_st)
  );

  kbc_trap_status #(.NUM_SRC(NUM_SRC)) u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (sts_clr_i),
    .en_i   (ctrl_q[NUM_SRC-1:0]),
    .sts_o  (sts_o),
    .smi_o  (smi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trap_q <= 1'b0;
    else         trap_q <= |set_vec[NUM_TRAP-1:0];
  end

  assign trap_o = trap_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/kbc_trap_chk.sv
module kbc_trap_chk
  import kbc_trap_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] CMD_GATE = 8'hD1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               io_vld_i,
  input logic               io_port_i,
  input logic               io_wr_i,
  input logic [DW-1:0]      io_data_i,
  input logic               usb_irq_i,
  input logic [NUM_SRC-1:0] sts_clr_i,
  input logic [CTRL_W-1:0]  ctrl_o,
  input logic [NUM_SRC-1:0] sts_o,
  input logic               trap_o,
  input logic               smi_o,
  input seq_st_e            seq_st_i
);
  // R3
  trap_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(io_vld_i));

  // R3
  trap_wr64_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_vld_i && io_port_i && io_wr_i && ctrl_o[3] && !ctrl_o[EN_PASS]) |=> trap_o);

  // R4
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (($past(sts_o) & ~$past(sts_clr_i) & ~sts_o) == '0));

  // R5
  smi_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> (sts_o != '0));

  // R5
  smi_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[NUM_SRC-1:0] == '0) |-> !smi_o);

  // R7
  usb_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (usb_irq_i && ctrl_o[SRC_USB]) |=> sts_o[SRC_USB]);

  // R8
  gate_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_vld_i && io_port_i && io_wr_i && io_data_i == CMD_GATE &&
     ctrl_o[EN_PASS] && seq_st_i != SEQ_DATA) |=> !trap_o);

  // R10
  dev_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_vld_i && !io_port_i && !io_wr_i && seq_st_i != SEQ_IDLE) |=> (seq_st_i == SEQ_IDLE));
endmodule

bind kbc_trap_ctrl kbc_trap_chk #(.DW(DW), .CMD_GATE(CMD_GATE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .io_vld_i  (io_vld_i),
  .io_port_i (io_port_i),
  .io_wr_i   (io_wr_i),
  .io_data_i (io_data_i),
  .usb_irq_i (usb_irq_i),
  .sts_clr_i (sts_clr_i),
  .ctrl_o    (ctrl_o),
  .sts_o     (sts_o),
  .trap_o    (trap_o),
  .smi_o     (smi_o),
  .seq_st_i  (seq_st)
);

// File: tb/kbc_trap_ctrl_bench.sv
module kbc_trap_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       vld, port, wr, usb, cfg_we;
  logic [7:0] data;
  logic [5:0] cfg_d, ctrl;
  logic [4:0] clr, sts;
  logic       trap, smi;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  kbc_trap_ctrl u_kbc_trap_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .io_vld_i(vld), .io_port_i(port), .io_wr_i(wr),
    .io_data_i(data), .usb_irq_i(usb), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_d),
    .sts_clr_i(clr), .ctrl_o(ctrl), .sts_o(sts), .trap_o(trap), .smi_o(smi)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [5:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_d = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic io(input logic p, input logic w, input logic [7:0] d);
    @(negedge clk); vld = 1'b1; port = p; wr = w; data = d;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic clear(input logic [4:0] m);
    @(negedge clk); clr = m;
    @(negedge clk); clr = '0;
  endtask

  task automatic quiet(input string tag);
    chk({tag, " trap"}, int'(trap), 0);
    chk({tag, " sts"}, int'(sts), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vld = 0; port = 0; wr = 0; data = 0; usb = 0;
    cfg_we = 0; cfg_d = 0; clr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ctrl", int'(ctrl), 0); chk("R1 sts", int'(sts), 0);
    chk("R1 trap", int'(trap), 0); chk("R1 smi", int'(smi), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sts after release", int'(sts), 0);

    // R2 R3 R5: every enable pattern against every access type
    for (int en = 0; en < 16; en++) begin
      for (int t = 0; t < 4; t++) begin
        int hit;
        cfg(6'(en));
        chk("R2 ctrl", int'(ctrl), en);
        io(t[1], t[0], 8'h5A);
        hit = (en >> t) & 1;
        chk("R3 trap pulse", int'(trap), hit);
        chk("R3 status", int'(sts), hit << t);
        chk("R5 smi", int'(smi), hit);
        @(negedge clk);
        chk("R3 trap one clock", int'(trap), 0);
        clear(5'h1F);
        chk("R4 clear all", int'(sts), 0);
      end
    end

    // R4 partial clear, R5 mask
    cfg(6'h0F);
    io(1'b0, 1'b0, 8'h00);
    io(1'b1, 1'b1, 8'h12);
    chk("R4 two set", int'(sts), 5'b01001);
    clear(5'b00001);
    chk("R4 partial clear", int'(sts), 5'b01000);
    chk("R5 smi held", int'(smi), 1);
    cfg(6'h07);
    chk("R5 smi masked", int'(smi), 0);
    chk("R5 status kept", int'(sts), 5'b01000);
    clear(5'h1F);

    // R6 set beats clear
    cfg(6'h0F);
    @(negedge clk); vld = 1; port = 0; wr = 1; data = 8'h01; clr = 5'b00010;
    @(negedge clk); vld = 0; clr = '0;
    chk("R6 set wins", int'(sts), 5'b00010);
    clear(5'h1F);

    // R7 usb source
    cfg(6'h0F);
    @(negedge clk); usb = 1;
    @(negedge clk); usb = 0;
    chk("R7 usb disabled", int'(sts), 0);
    cfg(6'h10);
    @(negedge clk); usb = 1;
    @(negedge clk); usb = 0;
    chk("R7 usb status", int'(sts), 5'b10000);
    chk("R7 usb smi", int'(smi), 1);
    chk("R7 no trap", int'(trap), 0);
    clear(5'h1F);
    chk("R7 cleared", int'(smi), 0);

    // R8 R9 full sequence with all enables
    cfg(6'h3F);
    io(1'b1, 1'b1, 8'hD1); quiet("R8 gate");
    io(1'b1, 1'b1, 8'hD1); quiet("R8 gate repeat");
    io(1'b0, 1'b1, 8'h33); quiet("R8 data");
    io(1'b1, 1'b0, 8'h00); quiet("R8 status read");
    io(1'b1, 1'b0, 8'h00); quiet("R8 status read 2");
    io(1'b1, 1'b1, 8'hFF); quiet("R8 end");
    chk("R8 smi", int'(smi), 0);
    io(1'b1, 1'b1, 8'hFF);
    chk("R9 idle trap", int'(trap), 1);
    chk("R9 idle status", int'(sts), 5'b01000);
    clear(5'h1F);
    io(1'b1, 1'b1, 8'hD1); io(1'b0, 1'b1, 8'hC3); io(1'b1, 1'b1, 8'hFF);
    quiet("R8 no reads");

    // R10 deviations at each stage
    for (int stg = 0; stg < 2; stg++) begin
      for (int dv = 0; dv < 3; dv++) begin
        logic dp, dw;
        logic [7:0] dd;
        int idx;
        if (stg == 0) begin
          dp = (dv != 0); dw = (dv == 2); dd = 8'h55;
        end else begin
          dp = (dv == 2); dw = (dv != 0); dd = 8'hD1;
        end
        idx = 2 * int'(dp) + int'(dw);
        clear(5'h1F);
        io(1'b1, 1'b1, 8'hD1);
        if (stg == 1) io(1'b0, 1'b1, 8'h44);
        quiet("R10 prefix");
        io(dp, dw, dd);
        chk("R10 deviation trap", int'(trap), 1);
        chk("R10 deviation status", int'(sts), 1 << idx);
        chk("R10 deviation smi", int'(smi), 1);
        io(1'b0, 1'b1, 8'h77);
        chk("R10 idle after exit", int'(trap), 1);
        chk("R10 idle status", int'(sts), (1 << idx) | 2);
      end
    end
    clear(5'h1F);

    // R11 pass-through disabled
    cfg(6'h0F);
    io(1'b1, 1'b1, 8'hD1);
    chk("R11 gate trapped", int'(trap), 1);
    io(1'b0, 1'b1, 8'h01);
    chk("R11 data trapped", int'(trap), 1);
    chk("R11 status", int'(sts), 5'b01010);
    clear(5'h1F);
    cfg(6'h3F);
    io(1'b1, 1'b1, 8'hD1);
    quiet("R11 gate in seq");
    cfg(6'h0F);
    cfg(6'h3F);
    io(1'b0, 1'b1, 8'h02);
    chk("R11 abandoned trap", int'(trap), 1);
    chk("R11 abandoned status", int'(sts), 5'b00010);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule